// File: doc/BRIEF.md
# Rotating XOR Hash Dictionary Lookup

This block decides whether a word belongs to a stored dictionary. A word arrives as a stream of 16-bit beats, each beat holding two 8-bit characters. Each accepted beat is folded into a running 18-bit signature. The fold XORs the running value with the zero-extended pair and with a per-instance constant, then rotates the result left by a fixed amount. When the final beat of a word is taken, the low bits of the resulting signature index a table of presence bits, and the registered answer appears one cycle later.

The dictionary is filled through a second beat stream that has the same shape. That stream runs its own signature register with the same fold. On its final beat it sets the presence bit at the word's index. A single-cycle clear command empties the whole table. The query and load streams are independent, so a word can be loaded while another is being looked up.

Both streams use valid/ready handshakes. A beat is consumed only on a cycle where its valid and ready are both high. Ready is held low only during a table-clear cycle, and a beat offered then simply waits. The result pins carry no back-pressure: the done pulse lasts one cycle, and the consumer must take it when it appears.

Top module: `dict_lookup`

## Requirements
- R1: One fold step maps signature h and pair p to rotl(h ^ {2'b00, p} ^ KEY, 7) on 18 bits. Here p[15:8] is the earlier character and p[7:0] the later one, and KEY is a per-instance parameter (default 18'h2B5A7).
- R2: A signature is zero at the start of every word. It returns to zero after a beat flagged last is accepted, and whenever the start strobe is high. A beat accepted together with the start strobe is folded onto zero.
- R3: The table index is the low IDX_W bits (default 10) of the signature. An accepted last load beat sets the presence bit at the index of the load word's final signature.
- R4: A last query beat accepted at clock edge k makes res_done high for exactly the cycle after edge k. In that cycle res_hit equals the presence bit at the query word's index.
- R5: res_hit is low whenever res_done is low.
- R6: A tbl_clear cycle empties every presence bit. During that cycle q_ready and ld_ready are low. In every other cycle both readies are high.
- R7: A beat offered with its valid low changes neither signature nor the result pins, even if its last flag is high. A non-last beat produces no done pulse.
- R8: When a load and a query finish on the same edge, the query reads the table as it stood before that load.
- R9: The load signature and the query signature advance independently when both streams carry beats of different words in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| q_start | input | 1 | Zero the query signature (start of word) |
| q_valid | input | 1 | Query beat offered |
| q_ready | output | 1 | Query beat can be taken |
| q_pair | input | 16 | Two query characters, earlier one in the upper byte |
| q_last | input | 1 | Query beat is the word's final pair |
| ld_start | input | 1 | Zero the load signature |
| ld_valid | input | 1 | Load beat offered |
| ld_ready | output | 1 | Load beat can be taken |
| ld_pair | input | 16 | Two load characters, earlier one in the upper byte |
| ld_last | input | 1 | Load beat is the word's final pair |
| tbl_clear | input | 1 | Empty the presence table this cycle |
| res_done | output | 1 | One-cycle pulse: lookup result valid |
| res_hit | output | 1 | Word found (meaningful with res_done) |

## Verification
A signature register that has drifted is invisible until a word ends. It then shows as a wrong res_hit in the cycle after the final beat. A load fold and a query fold that were wrong in the same way would still agree with each other, so the bench builds different words whose hand-computed signature equals that of a loaded word. A wrong rotation, constant or zero-extension then turns an expected hit into a miss. A stuck or stale presence bit shows on the next query that lands on that index. A done pulse out of place, or a ready that stays low after a clear, is visible in the very cycle it happens.

// File: rtl/dict_pkg.sv
package dict_pkg;
  // per-beat control of one signature accumulator
  typedef struct packed {
    logic start;  // zero the running signature
    logic fire;   // a beat is consumed this cycle
    logic last;   // consumed beat closes the word
  } beat_ctl_t;

  localparam int DEF_CHAR_W = 8;
  localparam int DEF_HASH_W = 18;
  localparam int DEF_ROT    = 7;
  localparam int DEF_IDX_W  = 10;
endpackage

// File: rtl/dict_hash_acc.sv
module dict_hash_acc
  import dict_pkg::*;
#(
  parameter int HASH_W = DEF_HASH_W,
  parameter int PAIR_W = 2 * DEF_CHAR_W,
  parameter int ROT    = DEF_ROT,
  parameter logic [HASH_W-1:0] KEY = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  beat_ctl_t         ctl,
  input  logic [PAIR_W-1:0] pair,
  output logic [HASH_W-1:0] h_next
);
  localparam int PAD = HASH_W - PAIR_W;
  localparam int RL  = ROT % HASH_W;

  logic [HASH_W-1:0] h_q;
  logic [HASH_W-1:0] base;
  logic [HASH_W-1:0] mix;

  always_comb begin
    base = ctl.start ? '0 : h_q;
    mix  = base ^ {{PAD{1'b0}}, pair} ^ KEY;
  end

  generate
    if (RL == 0) begin : g_norot
      assign h_next = mix;
    end else begin : g_rot
      assign h_next = {mix[HASH_W-RL-1:0], mix[HASH_W-1:HASH_W-RL]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)          h_q <= '0;
    else if (ctl.fire)   h_q <= ctl.last ? '0 : h_next;
    else if (ctl.start)  h_q <= '0;
  end
endmodule

// File: rtl/dict_valid_table.sv
module dict_valid_table #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [IDX_W-1:0] ridx,
  output logic             rbit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] vbits;

  always_ff @(posedge clk) begin
    if (!rst_n)   vbits <= '0;
    else if (clr) vbits <= '0;
    else if (we)  vbits[widx] <= 1'b1;
  end

  assign rbit = vbits[ridx];
endmodule

// File: rtl/dict_lookup.sv
module dict_lookup
  import dict_pkg::*;
#(
  parameter int CHAR_W = DEF_CHAR_W,
  parameter int HASH_W = DEF_HASH_W,
  parameter int ROT    = DEF_ROT,
  parameter int IDX_W  = DEF_IDX_W,
  parameter logic [HASH_W-1:0] KEY = 18'h2B5A7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_start,
  input  logic              q_valid,
  output logic              q_ready,
  input  logic [2*CHAR_W-1:0] q_pair,
  input  logic              q_last,
  input  logic              ld_start,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [2*CHAR_W-1:0] ld_pair,
  input  logic              ld_last,
  input  logic              tbl_clear,
  output logic              res_done,
  output logic              res_hit
);
  localparam int PAIR_W = 2 * CHAR_W;

  beat_ctl_t         q_ctl, l_ctl;
  logic [HASH_W-1:0] q_sig, l_sig;
  logic              rd_bit;

  assign q_ready = !tbl_clear;
  assign ld_ready = !tbl_clear;

  always_comb begin
    q_ctl.start = q_start;
    q_ctl.fire  = q_valid && q_ready;
    q_ctl.last  = q_last;
    l_ctl.start = ld_start;
    l_ctl.fire  = ld_valid && ld_ready;
    l_ctl.last  = ld_last;
  end

  dict_hash_acc #(.HASH_W(HASH_W), .PAIR_W(PAIR_W), .ROT(ROT), .KEY(KEY)) u_qhash (
    .clk(clk), .rst_n(rst_n), .ctl(q_ctl), .pair(q_pair), .h_next(q_sig)
  );

  dict_hash_acc #(.HASH_W(HASH_W), .PAIR_W(PAIR_W), .ROT(ROT), .KEY(KEY)) u_lhash (
    .clk(clk), .rst_n(rst_n), .ctl(l_ctl), .pair(ld_pair), .h_next(l_sig)
  );

  dict_valid_table #(.IDX_W(IDX_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .clr(tbl_clear),
    .we(l_ctl.fire && l_ctl.last),
    .widx(l_sig[IDX_W-1:0]),
    .ridx(q_sig[IDX_W-1:0]),
    .rbit(rd_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_done <= 1'b0;
      res_hit  <= 1'b0;
    end else begin
      res_done <= q_ctl.fire && q_ctl.last;
      res_hit  <= q_ctl.fire && q_ctl.last && rd_bit;
    end
  end
endmodule

// File: rtl/dict_lookup_chk.sv
module dict_lookup_chk #(
  parameter int IDX_W = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  q_valid,
  input logic                  q_ready,
  input logic                  q_last,
  input logic                  ld_valid,
  input logic                  ld_ready,
  input logic                  ld_last,
  input logic                  tbl_clear,
  input logic                  res_done,
  input logic                  res_hit,
  input logic [(1<<IDX_W)-1:0] vbits
);
  a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_ready && q_last) |=> res_done);

  a_r7_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_valid && q_ready && q_last) |=> !res_done);

  a_r5_hit_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    !res_done |-> !res_hit);

  a_r6_clear_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_clear |-> (!q_ready && !ld_ready));

  a_r6_ready_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !tbl_clear |-> (q_ready && ld_ready));

  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_clear |=> (vbits == '0));

  a_r3_load_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready && ld_last) |=> (vbits != '0));
endmodule

bind dict_lookup dict_lookup_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .q_valid(q_valid), .q_ready(q_ready), .q_last(q_last),
  .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_last(ld_last),
  .tbl_clear(tbl_clear), .res_done(res_done), .res_hit(res_hit),
  .vbits(u_tbl.vbits)
);

// File: tb/dict_lookup_test.sv
module dict_lookup_test;
  localparam int IW = 10;
  localparam int DEPTH = 1 << IW;
  localparam logic [17:0] KY = 18'h2B5A7;

  logic clk = 1'b0;
  logic rst_n;
  logic q_start, q_valid, q_last, ld_start, ld_valid, ld_last, tbl_clear;
  logic [15:0] q_pair, ld_pair;
  logic q_ready, ld_ready, res_done, res_hit;

  dict_lookup #(.CHAR_W(8), .HASH_W(18), .ROT(7), .IDX_W(IW), .KEY(KY)) uut (
    .clk(clk), .rst_n(rst_n),
    .q_start(q_start), .q_valid(q_valid), .q_ready(q_ready), .q_pair(q_pair), .q_last(q_last),
    .ld_start(ld_start), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_pair(ld_pair), .ld_last(ld_last),
    .tbl_clear(tbl_clear), .res_done(res_done), .res_hit(res_hit)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit mtab [DEPTH];
  logic [17:0] mqh, mlh;
  logic [15:0] lib [16][4];
  int libn [16];

  function automatic logic [17:0] rotl7(input logic [17:0] x);
    return {x[10:0], x[17:11]};
  endfunction
  function automatic logic [17:0] rotr7(input logic [17:0] x);
    return {x[6:0], x[17:7]};
  endfunction
  function automatic logic [17:0] fold(input logic [17:0] h, input logic [15:0] p);
    return rotl7(h ^ {2'b00, p} ^ KY);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one clock cycle: drive, check readies, pass the edge, check results, update model
  task automatic cyc(input bit qs, input bit qv, input logic [15:0] qp, input bit ql,
                     input bit ls, input bit lv, input logic [15:0] lp, input bit ll,
                     input bit clr, input string tag);
    bit qf, lf, ed, eh;
    logic [17:0] qn, ln;
    q_start = qs; q_valid = qv; q_pair = qp; q_last = ql;
    ld_start = ls; ld_valid = lv; ld_pair = lp; ld_last = ll;
    tbl_clear = clr;
    #1;
    chk(q_ready == !clr, "R6", "q_ready", q_ready, !clr);
    chk(ld_ready == !clr, "R6", "ld_ready", ld_ready, !clr);
    qf = qv && !clr;
    lf = lv && !clr;
    qn = fold(qs ? 18'd0 : mqh, qp);
    ln = fold(ls ? 18'd0 : mlh, lp);
    ed = qf && ql;
    eh = ed && mtab[qn[IW-1:0]];
    @(negedge clk);
    chk(res_done == ed, tag, "res_done", res_done, ed);
    chk(res_hit == eh, ed ? tag : "R5", "res_hit", res_hit, eh);
    if (qf) mqh = ql ? 18'd0 : qn; else if (qs) mqh = 18'd0;
    if (lf) mlh = ll ? 18'd0 : ln; else if (ls) mlh = 18'd0;
    if (clr) foreach (mtab[i]) mtab[i] = 1'b0;
    else if (lf && ll) mtab[ln[IW-1:0]] = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 16'h0, 0, 0, 0, 16'h0, 0, 0, "R7");
  endtask

  task automatic load2(input logic [15:0] a, input logic [15:0] b);
    cyc(0, 0, 16'h0, 0, 1, 1, a, 0, 0, "R3");
    cyc(0, 0, 16'h0, 0, 0, 1, b, 1, 0, "R3");
  endtask

  task automatic query2(input logic [15:0] a, input logic [15:0] b, input string tag);
    cyc(1, 1, a, 0, 0, 0, 16'h0, 0, 0, tag);
    cyc(0, 1, b, 1, 0, 0, 16'h0, 0, 0, tag);
  endtask

  // query a different two-pair word whose signature equals h exactly
  task automatic alias_query(input logic [17:0] h, input string tag);
    logic [15:0] p1;
    logic [17:0] p2;
    do begin
      p1 = 16'($urandom);
      p2 = rotr7(h) ^ KY ^ fold(18'd0, p1);
    end while (p2[17:16] != 2'b00);
    query2(p1, p2[15:0], tag);
  endtask

  initial begin
    void'($urandom(583));
    mqh = '0; mlh = '0;
    foreach (mtab[i]) mtab[i] = 1'b0;
    rst_n = 1'b0;
    q_start = 0; q_valid = 0; q_pair = 0; q_last = 0;
    ld_start = 0; ld_valid = 0; ld_pair = 0; ld_last = 0; tbl_clear = 0;
    repeat (3) @(negedge clk);
    chk(res_done == 1'b0, "R4", "reset res_done", res_done, 0);
    chk(res_hit == 1'b0, "R5", "reset res_hit", res_hit, 0);
    chk(q_ready == 1'b1, "R6", "reset q_ready", q_ready, 1);
    rst_n = 1'b1;
    idle(2);

    // R1 / R3: load one word, query it and a crafted alias
    load2(16'h7468, 16'h655F);
    chk(mtab[10'(fold(fold(0, 16'h7468), 16'h655F))] == 1'b1, "R3", "model mark", 1, 1);
    query2(16'h7468, 16'h655F, "R3");
    alias_query(fold(fold(0, 16'h7468), 16'h655F), "R1");
    alias_query(fold(fold(0, 16'h1234), 16'hABCD), "R1");
    query2(16'h0000, 16'h0001, "R1");

    // R2: stale partial word discarded by start strobe
    cyc(0, 1, 16'h1111, 0, 0, 0, 16'h0, 0, 0, "R7");
    cyc(1, 1, 16'h7468, 0, 0, 0, 16'h0, 0, 0, "R2");
    cyc(0, 1, 16'h655F, 1, 0, 0, 16'h0, 0, 0, "R2");
    cyc(0, 1, 16'h2222, 0, 0, 0, 16'h0, 0, 0, "R7");
    cyc(1, 0, 16'h3333, 0, 0, 0, 16'h0, 0, 0, "R2");
    cyc(0, 1, 16'h7468, 0, 0, 0, 16'h0, 0, 0, "R2");
    cyc(0, 1, 16'h655F, 1, 0, 0, 16'h0, 0, 0, "R2");

    // R7: idle beat with last high in the middle of a word
    cyc(1, 1, 16'h7468, 0, 0, 0, 16'h0, 0, 0, "R7");
    cyc(0, 0, 16'hFFFF, 1, 0, 0, 16'h0, 0, 0, "R7");
    cyc(0, 0, 16'h5A5A, 1, 0, 0, 16'h0, 0, 0, "R7");
    cyc(0, 1, 16'h655F, 1, 0, 0, 16'h0, 0, 0, "R7");

    // R8: load and query of a new word finish on the same edge
    cyc(1, 1, 16'h4E45, 1, 1, 1, 16'h4E45, 1, 0, "R8");
    cyc(1, 1, 16'h4E45, 1, 0, 0, 16'h0, 0, 0, "R8");

    // R9: three-pair load interleaved with a two-pair query
    cyc(1, 1, 16'h7468, 0, 1, 1, 16'h6162, 0, 0, "R9");
    cyc(0, 1, 16'h655F, 1, 0, 1, 16'h6364, 0, 0, "R9");
    cyc(1, 1, 16'h6162, 0, 0, 1, 16'h6566, 1, 0, "R9");
    cyc(0, 1, 16'h6364, 0, 0, 0, 16'h0, 0, 0, "R9");
    cyc(0, 1, 16'h6566, 1, 0, 0, 16'h0, 0, 0, "R9");

    // R6: clear while beats are offered, then earlier words miss
    cyc(1, 1, 16'h7468, 1, 1, 1, 16'h9999, 1, 1, "R6");
    query2(16'h7468, 16'h655F, "R6");
    cyc(1, 1, 16'h4E45, 1, 0, 0, 16'h0, 0, 0, "R6");
    cyc(1, 1, 16'h9999, 1, 0, 0, 16'h0, 0, 0, "R6");
    alias_query(fold(fold(0, 16'h7468), 16'h655F), "R6");

    // constrained random mix
    foreach (libn[i]) libn[i] = 0;
    for (int it = 0; it < 300; it++) begin
      int op = $urandom_range(0, 9);
      int s = $urandom_range(0, 15);
      if (op < 3) begin
        int n = $urandom_range(1, 3);
        libn[s] = n;
        for (int k = 0; k < n; k++) begin
          lib[s][k] = 16'($urandom);
          cyc(0, 0, 16'h0, 0, k == 0, 1, lib[s][k], k == n - 1, 0, "R3");
        end
      end else if (op < 6 && libn[s] > 0) begin
        for (int k = 0; k < libn[s]; k++)
          cyc(k == 0, 1, lib[s][k], k == libn[s] - 1, 0, 0, 16'h0, 0, 0, "R4");
      end else if (op < 8 && libn[s] > 0) begin
        logic [17:0] h = 18'd0;
        for (int k = 0; k < libn[s]; k++) h = fold(h, lib[s][k]);
        alias_query(h, "R1");
      end else if (op == 8) begin
        query2(16'($urandom), 16'($urandom), "R4");
      end else if ($urandom_range(0, 3) == 0) begin
        cyc(0, 0, 16'h0, 0, 0, 0, 16'h0, 0, 1, "R6");
      end else begin
        idle(1);
      end
    end
    idle(2);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule